// File: doc/BRIEF.md
# Timeslot-Gated Pseudo-Random Test Pattern Generator and Checker

This block puts a maximal-length test pattern with period 2^15-1 onto a 32-slot byte stream. It also checks the same pattern on the return stream. Each byte strobe carries a timeslot index, one transmit byte and one receive byte.

On the transmit side, a per-slot select mask decides which slots the generator overwrites. The generator advances by exactly one byte for each selected slot. Because of this, the pattern stays continuous even when the chosen slots are spread across the frame.

On the receive side, a second mask decides which slots feed the checker. The checker rebuilds the expected sequence from the bits it has already received, so it locks onto the pattern by itself. Every mismatched bit increments a saturating error counter, which software can clear. The checker only observes the receive stream and never alters it.

A single mode bit disconnects both masks. While it is set, the block is transparent and both sequence engines are frozen.

Top module: `prbs_slot_tester`

## Requirements
- R1: After reset the generator register holds all ones. Each generated bit is gen[14] XOR gen[13] (polynomial x^15+x^14+1). That bit is shifted into gen[0], and the eight bits of a byte are produced most significant bit first. The register never becomes zero.
- R2: When `test_off` is 0, a strobe in slot n with `tx_sel[n]`=1 replaces `tx_in` with the next generated byte on `tx_out`.
- R3: When `tx_sel[n]`=0 or `test_off`=1, a strobe copies `tx_in` to `tx_out`, and the generator does not advance.
- R4: The generator advances exactly one byte per selected transmit strobe. The sequence therefore continues unbroken across any set of selected slots, in the order they are strobed.
- R5: For a selected receive strobe (`rx_sel[n]`=1, `test_off`=0), each bit of `rx_in` is taken MSB first and compared with chk[14] XOR chk[13]. The checker register starts at zero after reset. The received bit is shifted into chk[0] whether or not it matched, and every mismatch adds one to `err_count`.
- R6: A receive strobe with `rx_sel[n]`=0 or `test_off`=1 changes neither `err_count` nor the checker register.
- R7: `err_count` is 16 bits wide and saturates at 16'hFFFF.
- R8: `err_clr`=1 sets `err_count` to 0 on the next edge. If a counting strobe falls in the same cycle, the clear wins, but the checker register still takes that byte.
- R9: Reset (`rst_n`=0) clears `tx_out` and `err_count` to zero.
- R10: `tx_out` is registered. It changes only on an edge where `byte_stb` is sampled high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_stb | input | 1 | A slot byte is present this cycle |
| slot_idx | input | 5 | Timeslot number of the present byte |
| test_off | input | 1 | 1 disables all pattern routing |
| tx_sel | input | 32 | Per-slot transmit generator select |
| rx_sel | input | 32 | Per-slot receive checker select |
| tx_in | input | 8 | System transmit byte |
| rx_in | input | 8 | Received byte |
| err_clr | input | 1 | Synchronous clear of the error counter |
| tx_out | output | 8 | Transmit byte after pattern insertion |
| err_count | output | 16 | Saturating bit-error count |

## Verification
Two functions can act in the same cycle: a clear request and a selected receive byte that carries bit errors. The bench produces this case by pulsing `err_clr` in the same strobe as a deliberately corrupted receive byte. It checks that the count reads zero afterwards. It then checks that the next byte's errors are counted against a checker state that did take in the cleared byte.

The same collision is also checked while the counter is pinned at its saturation value. For that, the bench first drives the counter to saturation with receive bytes whose every bit contradicts the prediction.

// File: rtl/prbs_slot_pkg.sv
package prbs_slot_pkg;
    localparam int unsigned SLOTS_DEF  = 32;
    localparam int unsigned BYTE_W_DEF = 8;
    localparam int unsigned LFSR_W_DEF = 15;
    localparam int unsigned TAP_B_DEF  = 13;
    localparam int unsigned CNT_W_DEF  = 16;

    typedef enum logic [1:0] {
        ROUTE_PASS = 2'd0,
        ROUTE_GEN  = 2'd1
    } route_e;
endpackage

// File: rtl/prbs_gen.sv
module prbs_gen #(
    parameter int unsigned LFSR_W = prbs_slot_pkg::LFSR_W_DEF,
    parameter int unsigned TAP_B  = prbs_slot_pkg::TAP_B_DEF,
    parameter int unsigned BYTE_W = prbs_slot_pkg::BYTE_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [BYTE_W-1:0] byte_o
);
    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
    } gen_st_t;

    gen_st_t st_d, st_q;
    logic [LFSR_W-1:0] walk;
    logic              fb;

    always_comb begin
        walk   = st_q.lfsr;
        byte_o = '0;
        fb     = 1'b0;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            fb        = walk[LFSR_W-1] ^ walk[TAP_B];
            byte_o[i] = fb;
            walk      = {walk[LFSR_W-2:0], fb};
        end
        st_d = st_q;
        if (adv) begin
            st_d.lfsr = walk;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.lfsr <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    AST_GEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lfsr != '0); // R1
endmodule

// File: rtl/prbs_chk.sv
module prbs_chk #(
    parameter int unsigned LFSR_W = prbs_slot_pkg::LFSR_W_DEF,
    parameter int unsigned TAP_B  = prbs_slot_pkg::TAP_B_DEF,
    parameter int unsigned BYTE_W = prbs_slot_pkg::BYTE_W_DEF,
    localparam int unsigned ERR_W = $clog2(BYTE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic [ERR_W-1:0]  err_bits
);
    typedef struct packed {
        logic [LFSR_W-1:0] ref_sr;
    } chk_st_t;

    chk_st_t st_d, st_q;
    logic [LFSR_W-1:0] walk;
    logic [BYTE_W-1:0] miss;
    logic              pred;

    always_comb begin
        walk = st_q.ref_sr;
        miss = '0;
        pred = 1'b0;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            pred    = walk[LFSR_W-1] ^ walk[TAP_B];
            miss[i] = pred ^ rx_byte[i];
            walk    = {walk[LFSR_W-2:0], rx_byte[i]};
        end
        err_bits = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            err_bits = err_bits + ERR_W'(miss[i]);
        end
        if (!adv) begin
            err_bits = '0;
        end
        st_d = st_q;
        if (adv) begin
            st_d.ref_sr = walk;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ref_sr <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_CHK_ERR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        err_bits <= ERR_W'(BYTE_W)); // R5
endmodule

// File: rtl/err_sat_counter.sv
module err_sat_counter #(
    parameter int unsigned CNT_W = prbs_slot_pkg::CNT_W_DEF,
    parameter int unsigned INC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [INC_W-1:0] inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

    typedef struct packed {
        logic [CNT_W-1:0] value;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [CNT_W:0] sum;

    always_comb begin
        sum  = {1'b0, st_q.value} + (CNT_W+1)'(inc);
        st_d = st_q;
        if (clr) begin
            st_d.value = '0;
        end else if (sum > CNT_MAX) begin
            st_d.value = '1;
        end else begin
            st_d.value = sum[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.value <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.value;

    AST_CNT_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.value == '1 && !clr) |=> st_q.value == '1); // R7
    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> st_q.value == '0); // R8
    AST_CNT_NO_DECREASE: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> st_q.value >= $past(st_q.value)); // R7
endmodule

// File: rtl/prbs_slot_tester.sv
module prbs_slot_tester #(
    parameter int unsigned SLOTS  = prbs_slot_pkg::SLOTS_DEF,
    parameter int unsigned BYTE_W = prbs_slot_pkg::BYTE_W_DEF,
    parameter int unsigned LFSR_W = prbs_slot_pkg::LFSR_W_DEF,
    parameter int unsigned TAP_B  = prbs_slot_pkg::TAP_B_DEF,
    parameter int unsigned CNT_W  = prbs_slot_pkg::CNT_W_DEF,
    localparam int unsigned IDX_W = $clog2(SLOTS),
    localparam int unsigned ERR_W = $clog2(BYTE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_stb,
    input  logic [IDX_W-1:0]  slot_idx,
    input  logic              test_off,
    input  logic [SLOTS-1:0]  tx_sel,
    input  logic [SLOTS-1:0]  rx_sel,
    input  logic [BYTE_W-1:0] tx_in,
    input  logic [BYTE_W-1:0] rx_in,
    input  logic              err_clr,
    output logic [BYTE_W-1:0] tx_out,
    output logic [CNT_W-1:0]  err_count
);
    import prbs_slot_pkg::*;

    typedef struct packed {
        logic [BYTE_W-1:0] txo;
    } top_st_t;

    top_st_t st_d, st_q;
    logic [SLOTS-1:0]  slot_dec;
    logic              tx_hit, rx_hit;
    route_e            route;
    logic [BYTE_W-1:0] gen_byte;
    logic [ERR_W-1:0]  err_bits;

    for (genvar s = 0; s < SLOTS; s++) begin : g_dec
        assign slot_dec[s] = (slot_idx == IDX_W'(s));
    end

    always_comb begin
        tx_hit = byte_stb && !test_off && |(slot_dec & tx_sel);
        rx_hit = byte_stb && !test_off && |(slot_dec & rx_sel);
        route  = tx_hit ? ROUTE_GEN : ROUTE_PASS;
        st_d   = st_q;
        if (byte_stb) begin
            st_d.txo = (route == ROUTE_GEN) ? gen_byte : tx_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.txo <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_out = st_q.txo;

    prbs_gen #(.LFSR_W(LFSR_W), .TAP_B(TAP_B), .BYTE_W(BYTE_W)) u_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (tx_hit),
        .byte_o (gen_byte)
    );

    prbs_chk #(.LFSR_W(LFSR_W), .TAP_B(TAP_B), .BYTE_W(BYTE_W)) u_chk (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (rx_hit),
        .rx_byte  (rx_in),
        .err_bits (err_bits)
    );

    err_sat_counter #(.CNT_W(CNT_W), .INC_W(ERR_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (err_clr),
        .inc   (err_bits),
        .cnt   (err_count)
    );

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && (test_off || !tx_sel[slot_idx])) |=> tx_out == $past(tx_in)); // R3
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_stb |=> $stable(tx_out)); // R10
    AST_NO_COUNT_UNSEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_clr && (!byte_stb || test_off || !rx_sel[slot_idx])) |=> $stable(err_count)); // R6
endmodule

// File: tb/prbs_slot_tester_bench.sv
module prbs_slot_tester_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_stb = 1'b0;
    logic [4:0]  slot_idx = '0;
    logic        test_off = 1'b0;
    logic [31:0] tx_sel = '0;
    logic [31:0] rx_sel = '0;
    logic [7:0]  tx_in = '0;
    logic [7:0]  rx_in = '0;
    logic        err_clr = 1'b0;
    logic [7:0]  tx_out;
    logic [15:0] err_count;

    int n_vec = 0;
    int n_bad = 0;

    logic [14:0] m_gen;
    logic [14:0] m_ref;
    logic [14:0] m_rx;
    int          m_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    prbs_slot_tester u_prbs_slot_tester (
        .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .slot_idx(slot_idx),
        .test_off(test_off), .tx_sel(tx_sel), .rx_sel(rx_sel), .tx_in(tx_in),
        .rx_in(rx_in), .err_clr(err_clr), .tx_out(tx_out), .err_count(err_count)
    );

    function automatic logic [7:0] next_pat(inout logic [14:0] s);
        logic [7:0] b;
        logic fb;
        for (int i = 7; i >= 0; i--) begin
            fb   = s[14] ^ s[13];
            b[i] = fb;
            s    = {s[13:0], fb};
        end
        return b;
    endfunction

    function automatic int count_miss(inout logic [14:0] r, input logic [7:0] d);
        int n = 0;
        for (int i = 7; i >= 0; i--) begin
            if ((r[14] ^ r[13]) != d[i]) n++;
            r = {r[13:0], d[i]};
        end
        return n;
    endfunction

    function automatic logic [7:0] all_wrong(input logic [14:0] r);
        logic [7:0] d;
        logic [14:0] w = r;
        for (int i = 7; i >= 0; i--) begin
            d[i] = ~(w[14] ^ w[13]);
            w    = {w[13:0], d[i]};
        end
        return d;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one slot from a negedge; sample at the following negedge.
    task automatic slot(input int idx, input logic [7:0] txd, input logic [7:0] rxd,
                        input logic clr, input string tag);
        logic txh, rxh;
        int exp_tx, n;
        txh = !test_off && tx_sel[idx];
        rxh = !test_off && rx_sel[idx];
        exp_tx = txh ? int'(next_pat(m_gen)) : int'(txd);
        n = rxh ? count_miss(m_rx, rxd) : 0;
        if (clr) m_cnt = 0;
        else m_cnt = (m_cnt + n > 65535) ? 65535 : m_cnt + n;
        byte_stb = 1'b1;
        slot_idx = 5'(idx);
        tx_in    = txd;
        rx_in    = rxd;
        err_clr  = clr;
        @(negedge clk);
        check({tag, " tx"}, int'(tx_out), exp_tx);
        check({tag, " cnt"}, int'(err_count), m_cnt);
    endtask

    task automatic frame(input string tag, input bit corrupt);
        for (int s = 0; s < 32; s++) begin
            logic [7:0] good;
            good = rx_sel[s] && !test_off ? next_pat(m_ref) : 8'h00;
            if (corrupt && (s % 7 == 3)) good ^= 8'h11;
            slot(s, 8'(s * 37 + 5), good, 1'b0, tag);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        m_gen = '1;
        m_ref = '1;
        m_rx  = '0;
        m_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        check("R9 tx_out", int'(tx_out), 0);
        check("R9 err_count", int'(err_count), 0);

        // R3 R6: mode bit set, masks ignored, engines frozen
        test_off = 1'b1;
        tx_sel = '1;
        rx_sel = '1;
        for (int s = 0; s < 32; s++) slot(s, 8'(s ^ 8'hC3), 8'(s * 11), 1'b0, "R3 R6 off");

        // R10 hold while strobe low
        byte_stb = 1'b0;
        tx_in = 8'h5A;
        @(negedge clk);
        check("R10 hold", int'(tx_out), int'(8'((31 ^ 8'hC3))));

        // R1 R2 R4 R5: sweep of slot masks, receive side tracks a clean copy
        test_off = 1'b0;
        tx_sel = '1;          rx_sel = '1;          frame("R1 R2 R5 full", 1'b0);
        tx_sel = 32'hA5A50F01; rx_sel = 32'hA5A50F01; frame("R4 scatter", 1'b0);
        tx_sel = '0;          rx_sel = 32'h0000FFFF; frame("R3 none", 1'b1);
        for (int b = 0; b < 32; b += 5) begin
            tx_sel = 32'h1 << b;
            rx_sel = ~(32'h1 << b);
            frame("R4 walk", 1'b1);
        end
        tx_sel = 32'h80000001; rx_sel = 32'h7FFFFFFE; frame("R6 sel", 1'b1);

        // R8 clear colliding with an erroring byte
        rx_sel = '1;
        slot(2, 8'h00, all_wrong(m_rx), 1'b1, "R8 clr+err");
        slot(3, 8'h00, all_wrong(m_rx), 1'b0, "R8 after");

        // R7 saturation
        for (int k = 0; k < 8200; k++) slot(k % 32, 8'h00, all_wrong(m_rx), 1'b0, "R7 sat");
        check("R7 at max", int'(err_count), 65535);
        slot(4, 8'h00, all_wrong(m_rx), 1'b1, "R8 clr at max");
        slot(5, 8'h00, all_wrong(m_rx), 1'b0, "R8 recount");

        byte_stb = 1'b0;
        err_clr  = 1'b0;
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule